// File: doc/BRIEF.md
# Rename-Stage Move Elimination Limiter

This block sits in the rename stage. Each cycle it looks at several instructions in program order, one per lane, and decides which register-to-register moves can be removed. A removed move does not execute: each of its destinations takes on the mapping of its source, and the block reports that source as the alias. Logical registers are split into physical register files by index; the top `FW` bits of a register number select the file. Each file has its own cap on eliminations per cycle, and a cap of zero means there is no cap. A file can also be set so that it only removes moves whose source is known to hold zero.

The block keeps one known-zero bit for every logical register. A removed move copies the zero status of its source to its destination. Any other write clears the destination's bit, unless that write is marked as a zero idiom, in which case it sets the bit. An instruction with two destinations is a swap. A swap is removed only as a whole: both pairs must qualify and the file must have a slot for each pair. Later lanes see the slot usage and zero status left by earlier lanes in the same cycle.

Top module: `mv_elim_limiter`

## Requirements
- R1: While reset is asserted, every response output and the whole known-zero vector are zero.
- R2: A move is removed only if, for each file its pairs belong to, the cap is 0 or the slots already used this cycle by earlier lanes plus this instruction's pairs in that file do not exceed the cap. Lane 0 is served first. Default caps: file 0 (registers 0 to 7) allows 2, file 1 (registers 8 to 15) has no cap.
- R3: `rsp_elim_cnt` carries one `CNT_W`-bit field per file, with file f at bits [f*CNT_W +: CNT_W]. Each field equals the number of pairs removed in that file in the reported cycle. The count starts from zero every cycle.
- R4: A pair qualifies only if its destination is set in `ELIG_MASK` and its source is in the same file as its destination. The default mask excludes registers 7 and 15.
- R5: In a file whose `ZERO_ONLY` bit is set (file 1 by default), a pair qualifies only if its source is known zero, as seen after all earlier lanes of the same cycle.
- R6: An instruction with both destination enables set is a swap. It is removed only if both pairs qualify and there are enough slots for both. Otherwise neither pair is removed.
- R7: For a removed instruction, the alias field of each enabled pair equals that pair's source. All other alias fields are zero. Pair p of lane l sits at `rsp_alias[(l*2+p)*RW +: RW]`, and the same packing is used for `req_dst` and `req_src`.
- R8: For a removed pair, the destination's known-zero bit takes the source's bit. Both pairs of a swap read the values from before the swap. Later lanes in the same cycle see the update.
- R9: For a write that is valid but not removed, the destination's known-zero bit is set if `req_zero_idiom` is 1 and cleared otherwise.
- R10: Responses appear on the cycle after the request. A lane with `req_valid` low, or with `req_move` low, is never removed, and an invalid lane leaves the known-zero vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | LANES | Lane holds an instruction |
| req_move | input | LANES | Instruction is a move or swap candidate |
| req_zero_idiom | input | LANES | Instruction's writes produce zero |
| req_def_en | input | LANES*2 | Destination enable per pair |
| req_dst | input | LANES*2*RW | Destination register per pair |
| req_src | input | LANES*2*RW | Source register per pair |
| rsp_valid | output | LANES | Registered copy of req_valid |
| rsp_elim | output | LANES | Lane's instruction was removed |
| rsp_alias | output | LANES*2*RW | Source register each removed pair aliases |
| rsp_elim_cnt | output | NUM_FILES*CNT_W | Pairs removed per file this cycle |
| known_zero | output | NUM_REGS | Known-zero bit per logical register |

## Verification
The directed patterns are chosen to separate the rules from one another:
- Three single moves into the capped file separate the cap test from a test on the lane index.
- A single move followed by a swap and another single move shows that a swap must reserve two slots, and that a rejected swap still leaves room for a later single move.
- A zero-only chain, where a later lane reads a zero bit that an earlier lane has just propagated, shows that zero status is forwarded within the cycle.
- A swap with one source known to be zero and the other not shows that the swap is rejected as a whole.
- Ineligible destinations and cross-file moves are each tried alone.

A long randomized run compares every output and the known-zero vector against an arithmetic model kept in the bench.

// File: rtl/mve_pkg.sv
package mve_pkg;

    // Each instruction carries at most this many destination/source pairs.
    localparam int PAIRS = 2;

    // Slot test: a cap of zero means unlimited.
    function automatic logic fits_limit(input logic [7:0] used,
                                        input logic [7:0] need,
                                        input logic [7:0] cap);
        logic [8:0] total;
        total = {1'b0, used} + {1'b0, need};
        return (cap == 8'd0) || (total <= {1'b0, cap});
    endfunction

endpackage

// File: rtl/mve_pair_check.sv
module mve_pair_check #(
    parameter int                   NUM_REGS  = 16,
    parameter int                   RW        = 4,
    parameter int                   NUM_FILES = 2,
    parameter int                   FW        = 1,
    parameter logic [NUM_REGS-1:0]  ELIG_MASK = '1,
    parameter logic [NUM_FILES-1:0] ZERO_ONLY = '0
) (
    input  logic [RW-1:0]       dst,
    input  logic [RW-1:0]       src,
    input  logic [NUM_REGS-1:0] zero_view,
    output logic                ok,
    output logic [FW-1:0]       file_idx
);

    logic [FW-1:0] src_file;

    generate
        if (NUM_FILES > 1) begin : g_split
            assign file_idx = dst[RW-1 -: FW];
            assign src_file = src[RW-1 -: FW];
        end else begin : g_single
            assign file_idx = '0;
            assign src_file = '0;
        end
    endgenerate

    always_comb begin
        ok = ELIG_MASK[dst] && (file_idx == src_file);
        if (ZERO_ONLY[file_idx] && !zero_view[src]) begin
            ok = 1'b0;
        end
    end

endmodule

// File: rtl/mve_lane.sv
module mve_lane
    import mve_pkg::*;
#(
    parameter int                          NUM_REGS  = 16,
    parameter int                          RW        = 4,
    parameter int                          NUM_FILES = 2,
    parameter int                          FW        = 1,
    parameter int                          CNT_W     = 3,
    parameter int                          CAP_W     = 4,
    parameter logic [NUM_FILES*CAP_W-1:0]  FILE_CAP  = '0,
    parameter logic [NUM_REGS-1:0]         ELIG_MASK = '1,
    parameter logic [NUM_FILES-1:0]        ZERO_ONLY = '0
) (
    input  logic                         valid,
    input  logic                         move,
    input  logic                         zidiom,
    input  logic [PAIRS-1:0]             def_en,
    input  logic [PAIRS*RW-1:0]          dst,
    input  logic [PAIRS*RW-1:0]          src,
    input  logic [NUM_REGS-1:0]          zero_in,
    input  logic [NUM_FILES*CNT_W-1:0]   cnt_in,
    output logic                         elim,
    output logic [PAIRS*RW-1:0]          alias_src,
    output logic [NUM_FILES*CNT_W-1:0]   cnt_out,
    output logic [NUM_REGS-1:0]          zero_out
);

    logic [PAIRS-1:0] pair_ok;
    logic [FW-1:0]    pair_file [PAIRS];
    logic [CNT_W-1:0] need      [NUM_FILES];
    logic             room;
    logic             pairs_ok;

    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            mve_pair_check #(
                .NUM_REGS  (NUM_REGS),
                .RW        (RW),
                .NUM_FILES (NUM_FILES),
                .FW        (FW),
                .ELIG_MASK (ELIG_MASK),
                .ZERO_ONLY (ZERO_ONLY)
            ) u_chk (
                .dst       (dst[p*RW +: RW]),
                .src       (src[p*RW +: RW]),
                .zero_view (zero_in),
                .ok        (pair_ok[p]),
                .file_idx  (pair_file[p])
            );
        end
    endgenerate

    // Slots this instruction needs in each file.
    always_comb begin
        for (int f = 0; f < NUM_FILES; f++) begin
            need[f] = '0;
            for (int p = 0; p < PAIRS; p++) begin
                if (def_en[p] && (pair_file[p] == FW'(f))) begin
                    need[f] = need[f] + CNT_W'(1);
                end
            end
        end
    end

    // All-or-nothing decision for the whole instruction.
    always_comb begin
        room = 1'b1;
        for (int f = 0; f < NUM_FILES; f++) begin
            if (!fits_limit(8'(cnt_in[f*CNT_W +: CNT_W]), 8'(need[f]),
                            8'(FILE_CAP[f*CAP_W +: CAP_W]))) begin
                room = 1'b0;
            end
        end
        pairs_ok = 1'b1;
        for (int p = 0; p < PAIRS; p++) begin
            if (def_en[p] && !pair_ok[p]) begin
                pairs_ok = 1'b0;
            end
        end
        elim = valid && move && (|def_en) && pairs_ok && room;
    end

    // Running counts, aliases and the zero view for the next lane.
    always_comb begin
        for (int f = 0; f < NUM_FILES; f++) begin
            cnt_out[f*CNT_W +: CNT_W] = cnt_in[f*CNT_W +: CNT_W] +
                                        (elim ? need[f] : '0);
        end
        zero_out  = zero_in;
        alias_src = '0;
        for (int p = 0; p < PAIRS; p++) begin
            if (valid && def_en[p]) begin
                if (elim) begin
                    zero_out[dst[p*RW +: RW]] = zero_in[src[p*RW +: RW]];
                    alias_src[p*RW +: RW]     = src[p*RW +: RW];
                end else begin
                    zero_out[dst[p*RW +: RW]] = zidiom;
                end
            end
        end
    end

endmodule

// File: rtl/mv_elim_limiter.sv
module mv_elim_limiter
    import mve_pkg::*;
#(
    parameter int                          NUM_REGS  = 16,
    parameter int                          NUM_FILES = 2,
    parameter int                          LANES     = 3,
    parameter int                          CAP_W     = 4,
    parameter logic [NUM_FILES*CAP_W-1:0]  FILE_CAP  = {4'd0, 4'd2},
    parameter logic [NUM_REGS-1:0]         ELIG_MASK = 16'h7F7F,
    parameter logic [NUM_FILES-1:0]        ZERO_ONLY = 2'b10,
    localparam int                         RW        = $clog2(NUM_REGS),
    localparam int                         CNT_W     = $clog2(LANES*PAIRS+1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             req_valid,
    input  logic [LANES-1:0]             req_move,
    input  logic [LANES-1:0]             req_zero_idiom,
    input  logic [LANES*PAIRS-1:0]       req_def_en,
    input  logic [LANES*PAIRS*RW-1:0]    req_dst,
    input  logic [LANES*PAIRS*RW-1:0]    req_src,
    output logic [LANES-1:0]             rsp_valid,
    output logic [LANES-1:0]             rsp_elim,
    output logic [LANES*PAIRS*RW-1:0]    rsp_alias,
    output logic [NUM_FILES*CNT_W-1:0]   rsp_elim_cnt,
    output logic [NUM_REGS-1:0]          known_zero
);

    localparam int FW = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1;

    typedef struct packed {
        logic [LANES-1:0]           vld;
        logic [LANES-1:0]           elim;
        logic [LANES*PAIRS*RW-1:0]  alias_v;
        logic [NUM_FILES*CNT_W-1:0] cnt;
        logic [NUM_REGS-1:0]        zero;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_REGS-1:0]        zchain [LANES+1];
    logic [NUM_FILES*CNT_W-1:0] cchain [LANES+1];
    logic [LANES-1:0]           lane_elim;
    logic [LANES*PAIRS*RW-1:0]  lane_alias;

    assign zchain[0] = st_q.zero;
    assign cchain[0] = '0;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            mve_lane #(
                .NUM_REGS  (NUM_REGS),
                .RW        (RW),
                .NUM_FILES (NUM_FILES),
                .FW        (FW),
                .CNT_W     (CNT_W),
                .CAP_W     (CAP_W),
                .FILE_CAP  (FILE_CAP),
                .ELIG_MASK (ELIG_MASK),
                .ZERO_ONLY (ZERO_ONLY)
            ) u_lane (
                .valid     (req_valid[l]),
                .move      (req_move[l]),
                .zidiom    (req_zero_idiom[l]),
                .def_en    (req_def_en[l*PAIRS +: PAIRS]),
                .dst       (req_dst[l*PAIRS*RW +: PAIRS*RW]),
                .src       (req_src[l*PAIRS*RW +: PAIRS*RW]),
                .zero_in   (zchain[l]),
                .cnt_in    (cchain[l]),
                .elim      (lane_elim[l]),
                .alias_src (lane_alias[l*PAIRS*RW +: PAIRS*RW]),
                .cnt_out   (cchain[l+1]),
                .zero_out  (zchain[l+1])
            );
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        st_d.vld     = req_valid;
        st_d.elim    = lane_elim;
        st_d.alias_v = lane_alias;
        st_d.cnt     = cchain[LANES];
        st_d.zero    = zchain[LANES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.vld;
    assign rsp_elim     = st_q.elim;
    assign rsp_alias    = st_q.alias_v;
    assign rsp_elim_cnt = st_q.cnt;
    assign known_zero   = st_q.zero;

endmodule

// File: rtl/mve_checker.sv
module mve_checker
    import mve_pkg::*;
#(
    parameter int                          NUM_REGS  = 16,
    parameter int                          NUM_FILES = 2,
    parameter int                          LANES     = 3,
    parameter int                          CAP_W     = 4,
    parameter logic [NUM_FILES*CAP_W-1:0]  FILE_CAP  = '0,
    parameter logic [NUM_REGS-1:0]         ELIG_MASK = '1,
    localparam int                         RW        = $clog2(NUM_REGS),
    localparam int                         CNT_W     = $clog2(LANES*PAIRS+1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [LANES-1:0]             req_valid,
    input logic [LANES-1:0]             req_move,
    input logic [LANES*PAIRS-1:0]       req_def_en,
    input logic [LANES*PAIRS*RW-1:0]    req_dst,
    input logic [LANES*PAIRS*RW-1:0]    req_src,
    input logic [LANES-1:0]             rsp_valid,
    input logic [LANES-1:0]             rsp_elim,
    input logic [LANES*PAIRS*RW-1:0]    rsp_alias,
    input logic [NUM_FILES*CNT_W-1:0]   rsp_elim_cnt
);

    logic [LANES*PAIRS-1:0] def_q;
    logic [7:0]             tot_cnt;
    logic [7:0]             tot_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            def_q <= '0;
        end else begin
            def_q <= req_def_en;
        end
    end

    always_comb begin
        tot_cnt = '0;
        for (int f = 0; f < NUM_FILES; f++) begin
            tot_cnt = tot_cnt + 8'(rsp_elim_cnt[f*CNT_W +: CNT_W]);
        end
        tot_exp = '0;
        for (int l = 0; l < LANES; l++) begin
            if (rsp_elim[l]) begin
                tot_exp = tot_exp + 8'($countones(def_q[l*PAIRS +: PAIRS]));
            end
        end
    end

    // R3: reported per-file counts add up to the pairs actually removed
    assert_cnt_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tot_cnt == tot_exp);

    // R10: response valid mirrors the request one cycle later
    assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> rsp_valid == $past(req_valid));

    generate
        for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
            if (FILE_CAP[f*CAP_W +: CAP_W] != 0) begin : g_capped
                // R2: a capped file never exceeds its per-cycle cap
                assert_cap_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    8'(rsp_elim_cnt[f*CNT_W +: CNT_W]) <= 8'(FILE_CAP[f*CAP_W +: CAP_W]));
            end
        end
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // R10: only valid move requests can be removed
            assert_elim_needs_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_elim[l] |-> $past(req_valid[l] && req_move[l]));
            // R7: a lane that was not removed reports no alias
            assert_quiet_alias_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !rsp_elim[l] |-> rsp_alias[l*PAIRS*RW +: PAIRS*RW] == '0);
            for (genvar p = 0; p < PAIRS; p++) begin : g_pair
                // R7: removed pair aliases its source
                assert_alias_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (rsp_elim[l] && $past(req_def_en[l*PAIRS+p])) |->
                    rsp_alias[(l*PAIRS+p)*RW +: RW] == $past(req_src[(l*PAIRS+p)*RW +: RW]));
                // R4: removed pair had an eligible destination
                assert_elig_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (rsp_elim[l] && $past(req_def_en[l*PAIRS+p])) |->
                    ELIG_MASK[$past(req_dst[(l*PAIRS+p)*RW +: RW])]);
            end
        end
    endgenerate

endmodule

bind mv_elim_limiter mve_checker #(
    .NUM_REGS  (NUM_REGS),
    .NUM_FILES (NUM_FILES),
    .LANES     (LANES),
    .CAP_W     (CAP_W),
    .FILE_CAP  (FILE_CAP),
    .ELIG_MASK (ELIG_MASK)
) u_mve_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_move     (req_move),
    .req_def_en   (req_def_en),
    .req_dst      (req_dst),
    .req_src      (req_src),
    .rsp_valid    (rsp_valid),
    .rsp_elim     (rsp_elim),
    .rsp_alias    (rsp_alias),
    .rsp_elim_cnt (rsp_elim_cnt)
);

// File: tb/mv_elim_limiter_bench.sv
`timescale 1ns/1ps
module mv_elim_limiter_bench;

    localparam logic [15:0] ELIG = 16'h7F7F;
    localparam int          CAP0 = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  req_valid, req_move, req_zero_idiom;
    logic [5:0]  req_def_en;
    logic [23:0] req_dst, req_src;
    logic [2:0]  rsp_valid, rsp_elim;
    logic [23:0] rsp_alias;
    logic [5:0]  rsp_elim_cnt;
    logic [15:0] known_zero;

    int checks = 0;
    int errors = 0;

    logic       v [3];
    logic       mv [3];
    logic       zi [3];
    logic [1:0] de [3];
    logic [3:0] d [3][2];
    logic [3:0] s [3][2];

    logic [15:0] mz;
    logic [2:0]  e_vld, e_elim;
    logic [23:0] e_alias;
    logic [5:0]  e_cnt;
    logic [15:0] e_zero;
    logic [15:0] saved_zero;

    always #2 clk = ~clk;

    mv_elim_limiter u_mv_elim_limiter (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_move       (req_move),
        .req_zero_idiom (req_zero_idiom),
        .req_def_en     (req_def_en),
        .req_dst        (req_dst),
        .req_src        (req_src),
        .rsp_valid      (rsp_valid),
        .rsp_elim       (rsp_elim),
        .rsp_alias      (rsp_alias),
        .rsp_elim_cnt   (rsp_elim_cnt),
        .known_zero     (known_zero)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_req();
        for (int l = 0; l < 3; l++) begin
            v[l] = 0; mv[l] = 0; zi[l] = 0; de[l] = 0;
            for (int p = 0; p < 2; p++) begin
                d[l][p] = 0; s[l][p] = 0;
            end
        end
    endtask

    task automatic put(input int l, input logic m, input logic z, input logic [1:0] en,
                       input logic [3:0] d0, input logic [3:0] s0,
                       input logic [3:0] d1, input logic [3:0] s1);
        v[l] = 1; mv[l] = m; zi[l] = z; de[l] = en;
        d[l][0] = d0; s[l][0] = s0; d[l][1] = d1; s[l][1] = s1;
    endtask

    task automatic model();
        logic [15:0] z;
        int c0, c1;
        z = mz; c0 = 0; c1 = 0; e_elim = '0; e_alias = '0;
        for (int l = 0; l < 3; l++) begin
            logic ok, el;
            int n0, n1;
            logic [15:0] zt;
            e_vld[l] = v[l];
            ok = 1; n0 = 0; n1 = 0;
            for (int p = 0; p < 2; p++) begin
                if (de[l][p]) begin
                    if (!ELIG[d[l][p]]) ok = 0;
                    if (d[l][p][3] != s[l][p][3]) ok = 0;
                    if (d[l][p][3] && !z[s[l][p]]) ok = 0;
                    if (d[l][p][3]) n1++; else n0++;
                end
            end
            el = v[l] && mv[l] && (de[l] != 0) && ok && (c0 + n0 <= CAP0);
            e_elim[l] = el;
            if (el) begin
                c0 += n0; c1 += n1;
            end
            zt = z;
            for (int p = 0; p < 2; p++) begin
                if (v[l] && de[l][p]) begin
                    zt[d[l][p]] = el ? z[s[l][p]] : zi[l];
                    if (el) e_alias[(l*2+p)*4 +: 4] = s[l][p];
                end
            end
            z = zt;
        end
        e_cnt = {3'(c1), 3'(c0)};
        mz = z;
        e_zero = z;
    endtask

    task automatic run(input string tag);
        for (int l = 0; l < 3; l++) begin
            req_valid[l] = v[l]; req_move[l] = mv[l]; req_zero_idiom[l] = zi[l];
            for (int p = 0; p < 2; p++) begin
                req_def_en[l*2+p]          = de[l][p];
                req_dst[(l*2+p)*4 +: 4]    = d[l][p];
                req_src[(l*2+p)*4 +: 4]    = s[l][p];
            end
        end
        model();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rsp_valid",    32'(rsp_valid),    32'(e_vld));
        chk(tag, "rsp_elim",     32'(rsp_elim),     32'(e_elim));
        chk(tag, "rsp_alias",    32'(rsp_alias),    32'(e_alias));
        chk(tag, "rsp_elim_cnt", 32'(rsp_elim_cnt), 32'(e_cnt));
        chk(tag, "known_zero",   32'(known_zero),   32'(e_zero));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0;
        mz = '0;
        clear_req();
        req_valid = '0; req_move = '0; req_zero_idiom = '0;
        req_def_en = '0; req_dst = '0; req_src = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: everything clear in reset
        chk("R1", "rsp_valid",    32'(rsp_valid), 0);
        chk("R1", "rsp_elim",     32'(rsp_elim), 0);
        chk("R1", "rsp_alias",    32'(rsp_alias), 0);
        chk("R1", "rsp_elim_cnt", 32'(rsp_elim_cnt), 0);
        chk("R1", "known_zero",   32'(known_zero), 0);
        rst_n = 1;

        // R9: zero idioms set bits 3, 9 and 12
        clear_req();
        put(0, 0, 1, 2'b01, 4'd3, 4'd0, 4'd0, 4'd0);
        put(1, 0, 1, 2'b01, 4'd9, 4'd0, 4'd0, 4'd0);
        put(2, 0, 1, 2'b01, 4'd12, 4'd0, 4'd0, 4'd0);
        run("R9");
        chk("R9", "idiom vector", 32'(known_zero), 32'h1208);
        // R9: a plain write clears bit 12
        clear_req();
        put(0, 0, 0, 2'b01, 4'd12, 4'd1, 4'd0, 4'd0);
        run("R9");
        chk("R9", "plain write clears", 32'(known_zero), 32'h0208);

        // R2: three moves into capped file 0, third rejected
        clear_req();
        put(0, 1, 0, 2'b01, 4'd1, 4'd2, 4'd0, 4'd0);
        put(1, 1, 0, 2'b01, 4'd4, 4'd5, 4'd0, 4'd0);
        put(2, 1, 0, 2'b01, 4'd6, 4'd0, 4'd0, 4'd0);
        run("R2");
        chk("R2", "cap of two", 32'(rsp_elim), 32'b011);
        chk("R3", "file0 count", 32'(rsp_elim_cnt[2:0]), 2);
        chk("R7", "lane0 alias", 32'(rsp_alias[3:0]), 2);

        // R3: count restarts next cycle
        clear_req();
        put(0, 1, 0, 2'b01, 4'd5, 4'd1, 4'd0, 4'd0);
        run("R3");
        chk("R3", "count restarts", 32'(rsp_elim_cnt[2:0]), 1);

        // R6: swap needs two slots; only one left after lane 0
        clear_req();
        put(0, 1, 0, 2'b01, 4'd1, 4'd2, 4'd0, 4'd0);
        put(1, 1, 0, 2'b11, 4'd3, 4'd4, 4'd4, 4'd3);
        put(2, 1, 0, 2'b01, 4'd5, 4'd6, 4'd0, 4'd0);
        run("R6");
        chk("R6", "swap rejected, lane2 taken", 32'(rsp_elim), 32'b101);
        chk("R6", "file0 count", 32'(rsp_elim_cnt[2:0]), 2);
        // R6: swap alone fits
        clear_req();
        put(0, 1, 0, 2'b11, 4'd3, 4'd4, 4'd4, 4'd3);
        run("R6");
        chk("R6", "swap accepted", 32'(rsp_elim), 32'b001);
        chk("R7", "swap aliases", 32'(rsp_alias[7:0]), 32'h34);

        // R5 / R8: zero-only file 1 with forwarding between lanes
        clear_req();
        put(0, 1, 0, 2'b01, 4'd8, 4'd9, 4'd0, 4'd0);
        put(1, 1, 0, 2'b01, 4'd10, 4'd11, 4'd0, 4'd0);
        put(2, 1, 0, 2'b01, 4'd11, 4'd8, 4'd0, 4'd0);
        run("R5");
        chk("R5", "zero-only decisions", 32'(rsp_elim), 32'b101);
        chk("R3", "file1 count", 32'(rsp_elim_cnt[5:3]), 2);
        chk("R8", "bit8 propagated", 32'(known_zero[8]), 1);
        chk("R8", "bit11 forwarded", 32'(known_zero[11]), 1);

        // R6: swap with one non-zero source rejected as a whole
        clear_req();
        put(0, 1, 0, 2'b11, 4'd9, 4'd10, 4'd10, 4'd9);
        run("R6");
        chk("R6", "partial swap rejected", 32'(rsp_elim), 0);
        chk("R9", "bits 9,10 cleared", 32'(known_zero[10:9]), 0);

        // R4 / R7: ineligible and cross-file moves
        clear_req();
        put(0, 1, 0, 2'b01, 4'd7, 4'd1, 4'd0, 4'd0);
        put(1, 1, 0, 2'b01, 4'd2, 4'd9, 4'd0, 4'd0);
        put(2, 1, 0, 2'b01, 4'd15, 4'd8, 4'd0, 4'd0);
        run("R4");
        chk("R4", "none removed", 32'(rsp_elim), 0);
        chk("R7", "no aliases", 32'(rsp_alias), 0);

        // R10: invalid lanes change nothing
        saved_zero = known_zero;
        clear_req();
        for (int l = 0; l < 3; l++) begin
            put(l, 1, 1, 2'b01, 4'd9, 4'd8, 4'd0, 4'd0);
            v[l] = 0;
        end
        run("R10");
        chk("R10", "invalid no elim", 32'(rsp_elim), 0);
        chk("R10", "zero unchanged", 32'(known_zero), 32'(saved_zero));

        // Randomized sweep against the bench model (R2..R10)
        for (int n = 0; n < 3000; n++) begin
            for (int l = 0; l < 3; l++) begin
                v[l]  = ($urandom % 4) != 0;
                mv[l] = ($urandom % 3) != 0;
                zi[l] = ($urandom % 3) == 0;
                de[l] = 2'($urandom % 4);
                for (int p = 0; p < 2; p++) begin
                    d[l][p] = 4'($urandom);
                    s[l][p] = 4'($urandom);
                    if (($urandom % 5) != 0) s[l][p][3] = d[l][p][3];
                end
            end
            run("R2_R10_sweep");
        end

        summary();
        $finish;
    end

endmodule